// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block is the register front end of an I/O interrupt controller. A bus master sees just two 32-bit locations: a select register and a data window. The value held in the select register chooses what the window reaches. That can be a read-only version word, a 4-bit controller identifier, or a read-only arbitration word that mirrors the identifier. It can also be one half of a 64-bit routing entry. There is one routing entry per interrupt input pin.

The block stores every routing entry and publishes the per-pin fields to the pin logic next to it. Those fields are mask, trigger mode, polarity, vector, delivery mode, destination mode and destination. The pin logic sends back two things: its pending-request bits and a set strobe for each pin's remote-IRR flag. The register file produces three outputs for the pin logic: a remote-IRR clear pulse, a service request for a pin whose request is still pending after its entry was rewritten, and a mask-change event. Interrupt delivery and bus error responses are handled elsewhere.

Top module: `irq_route_regfile`

## Requirements
- R1: Only two bus offsets respond. Offset 0x00 is the 32-bit select register and reads back its stored value. Offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: Read data is valid on `rd_data`, with `rd_valid` high for one cycle, in the cycle after the read request is accepted.
- R3: Select value 0x01 is the version word. It reads (NPINS−1) in bits 23:16 and VERSION_ID in bits 7:0, and every other bit is 0. Writes to it are ignored.
- R4: Select value 0x00 is the identifier word. A write stores wdata[27:24], and a read returns that value in bits 27:24 with every other bit 0. Select value 0x02 reads the same word, and writes to 0x02 are ignored.
- R5: A select value of 0x10 or more addresses entry index (select−0x10)>>1. An odd select value reaches bits 63:32 of the entry and an even value reaches bits 31:0. The low half is laid out as follows: vector 7:0, delivery mode 10:8, destination mode 11, bit 12 always reads 0, polarity 13, remote IRR 14 (read-only), trigger mode 15, mask 16, and bits 31:17 read 0. In the high half, the destination is bits 31:24 and all other bits read 0. Every stored field appears on the matching per-pin output.
- R6: If the entry index is NPINS or more, a write changes nothing and a read returns 0.
- R7: A set strobe on `rirr_set[i]` sets remote IRR for pin i. A write to the low half of entry i clears it, and this clear has priority over a set strobe in the same cycle. The clear also makes `rirr_clr[i]` pulse for one cycle, in the next cycle. A write to the high half leaves remote IRR unchanged.
- R8: If an entry write for pin i is accepted while `pin_request[i]` is 1, `svc_req` equals one-hot bit i for exactly one cycle, in the next cycle. In every other cycle `svc_req` is 0.
- R9: If a low-half write changes an entry's mask bit, then in the next cycle `mask_chg_vld` pulses for one cycle, `mask_chg_pin` holds the entry index and `mask_chg_val` holds the new mask value. A write that leaves the mask bit unchanged produces no pulse.
- R10: A write is accepted only when `bus_size` is 4 or 8, and only the 32-bit `bus_wdata` is used. A write of any other size has no effect.
- R11: After reset, every mask bit is 1. The select register, the identifier, remote IRR and all other entry fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pin_request | input | NPINS | Pending request bits from the pin logic |
| rirr_set | input | NPINS | Remote-IRR set strobes |
| ent_mask | output | NPINS | Per-pin mask |
| ent_trig | output | NPINS | Per-pin trigger mode (1 = level) |
| ent_pol | output | NPINS | Per-pin polarity (1 = active low) |
| ent_dmode | output | NPINS | Per-pin destination mode |
| ent_vector | output | 8*NPINS | Per-pin vector, pin i in bits 8i+7:8i |
| ent_deliv | output | 3*NPINS | Per-pin delivery mode, pin i in bits 3i+2:3i |
| ent_dest | output | 8*NPINS | Per-pin destination, pin i in bits 8i+7:8i |
| remote_irr | output | NPINS | Per-pin remote-IRR flag |
| rirr_clr | output | NPINS | Remote-IRR clear pulse |
| svc_req | output | NPINS | One-hot service request pulse |
| mask_chg_vld | output | 1 | Mask change event |
| mask_chg_pin | output | $clog2(NPINS) | Index of the pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |

## Verification
A wrong entry index or a wrong half selection writes the data into the wrong place. That place is either a neighbouring pin's field outputs or the other half of the entry, and the error shows on the port the next cycle and again when the word is read back. Stale remote-IRR or mask state shows in three places: bit 14 or bit 16 of the low-half read, the per-pin outputs, and the pulses on `rirr_clr`, `svc_req` and `mask_chg_vld`. All three pulses are due exactly one cycle after the write, so a pulse that is missing, late or sent to the wrong pin shows at once. A size filter or offset decode that lets a write through shows up on the next read of the word that write targeted.

// File: rtl/irq_route_regfile.sv
module irq_route_regfile #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION_ID = 8'h11,
  localparam int IW = $clog2(NPINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [7:0]          bus_addr,
  input  logic [3:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NPINS-1:0]    pin_request,
  input  logic [NPINS-1:0]    rirr_set,
  output logic [NPINS-1:0]    ent_mask,
  output logic [NPINS-1:0]    ent_trig,
  output logic [NPINS-1:0]    ent_pol,
  output logic [NPINS-1:0]    ent_dmode,
  output logic [8*NPINS-1:0]  ent_vector,
  output logic [3*NPINS-1:0]  ent_deliv,
  output logic [8*NPINS-1:0]  ent_dest,
  output logic [NPINS-1:0]    remote_irr,
  output logic [NPINS-1:0]    rirr_clr,
  output logic [NPINS-1:0]    svc_req,
  output logic                mask_chg_vld,
  output logic [IW-1:0]       mask_chg_pin,
  output logic                mask_chg_val
);

  localparam logic [7:0]  OFS_SEL = 8'h00;
  localparam logic [7:0]  OFS_WIN = 8'h10;
  localparam logic [31:0] IX_ID   = 32'h0;
  localparam logic [31:0] IX_VER  = 32'h1;
  localparam logic [31:0] IX_ARB  = 32'h2;
  localparam logic [31:0] IX_TBL  = 32'h10;
  localparam logic [7:0]  TOP_PIN = 8'(NPINS - 1);

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic [7:0]  vec_q [NPINS];
  logic [2:0]  dlv_q [NPINS];
  logic [7:0]  dst_q [NPINS];
  logic [NPINS-1:0] msk_q, trg_q, pol_q, dmd_q, rirr_q;

  logic [31:0] tbl_off;
  logic [30:0] tbl_ix;
  logic        ix_ok, hi_half;
  logic [IW-1:0] ix;

  assign tbl_off = sel_q - IX_TBL;
  assign tbl_ix  = tbl_off[31:1];
  assign ix_ok   = (sel_q >= IX_TBL) && (tbl_ix < 31'(NPINS));
  assign ix      = tbl_ix[IW-1:0];
  assign hi_half = tbl_off[0];

  logic wr_ok, sel_wr, win_wr, ent_wr, lo_wr, hi_wr, id_wr, rd_req;

  assign wr_ok  = bus_valid && bus_write && (bus_size == 4'd4 || bus_size == 4'd8);
  assign sel_wr = wr_ok && bus_addr == OFS_SEL;
  assign win_wr = wr_ok && bus_addr == OFS_WIN;
  assign ent_wr = win_wr && ix_ok;
  assign lo_wr  = ent_wr && !hi_half;
  assign hi_wr  = ent_wr && hi_half;
  assign id_wr  = win_wr && sel_q == IX_ID;
  assign rd_req = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (id_wr)  id_q  <= bus_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPINS; i++) begin
      if (!rst_n) begin
        vec_q[i]  <= '0;
        dlv_q[i]  <= '0;
        dst_q[i]  <= '0;
        msk_q[i]  <= 1'b1;
        trg_q[i]  <= 1'b0;
        pol_q[i]  <= 1'b0;
        dmd_q[i]  <= 1'b0;
        rirr_q[i] <= 1'b0;
      end else begin
        if (lo_wr && ix == IW'(i)) begin
          vec_q[i]  <= bus_wdata[7:0];
          dlv_q[i]  <= bus_wdata[10:8];
          dmd_q[i]  <= bus_wdata[11];
          pol_q[i]  <= bus_wdata[13];
          trg_q[i]  <= bus_wdata[15];
          msk_q[i]  <= bus_wdata[16];
          rirr_q[i] <= 1'b0;
        end else if (rirr_set[i]) begin
          rirr_q[i] <= 1'b1;
        end
        if (hi_wr && ix == IW'(i))
          dst_q[i] <= bus_wdata[31:24];
      end
    end
  end

  logic [31:0] lo_word, hi_word, win_word;

  assign lo_word = {15'b0, msk_q[ix], trg_q[ix], rirr_q[ix], pol_q[ix], 1'b0,
                    dmd_q[ix], dlv_q[ix], vec_q[ix]};
  assign hi_word = {dst_q[ix], 24'b0};

  always_comb begin
    case (sel_q)
      IX_ID, IX_ARB: win_word = {4'b0, id_q, 24'b0};
      IX_VER:        win_word = {8'b0, TOP_PIN, 8'b0, VERSION_ID};
      default:       win_word = ix_ok ? (hi_half ? hi_word : lo_word) : 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= (bus_addr == OFS_SEL) ? sel_q :
                   (bus_addr == OFS_WIN) ? win_word : 32'b0;
    end
  end

  logic [NPINS-1:0] ix_hot;
  assign ix_hot = NPINS'(1) << ix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_clr     <= '0;
      svc_req      <= '0;
      mask_chg_vld <= 1'b0;
      mask_chg_pin <= '0;
      mask_chg_val <= 1'b0;
    end else begin
      rirr_clr     <= lo_wr ? ix_hot : '0;
      svc_req      <= (ent_wr && pin_request[ix]) ? ix_hot : '0;
      mask_chg_vld <= lo_wr && (bus_wdata[16] != msk_q[ix]);
      if (lo_wr) begin
        mask_chg_pin <= ix;
        mask_chg_val <= bus_wdata[16];
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pub
    assign ent_vector[8*g +: 8] = vec_q[g];
    assign ent_deliv[3*g +: 3]  = dlv_q[g];
    assign ent_dest[8*g +: 8]   = dst_q[g];
  end

  assign ent_mask   = msk_q;
  assign ent_trig   = trg_q;
  assign ent_pol    = pol_q;
  assign ent_dmode  = dmd_q;
  assign remote_irr = rirr_q;

  assert_rd_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  assert_svc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_req));

  assert_mask_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> (ent_mask[mask_chg_pin] == mask_chg_val));

  assert_rirr_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_clr) |-> ((rirr_clr & remote_irr) == '0));

endmodule

// File: tb/sim_irq_route_regfile.sv
module sim_irq_route_regfile;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_size = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [NP-1:0] pin_request = '0, rirr_set = '0;
  logic [NP-1:0] ent_mask, ent_trig, ent_pol, ent_dmode, remote_irr, rirr_clr, svc_req;
  logic [8*NP-1:0] ent_vector, ent_dest;
  logic [3*NP-1:0] ent_deliv;
  logic mask_chg_vld, mask_chg_val;
  logic [IW-1:0] mask_chg_pin;

  int errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  irq_route_regfile #(.NPINS(NP), .VERSION_ID(8'h11)) u0 (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
    .rd_valid, .rd_data, .pin_request, .rirr_set, .ent_mask, .ent_trig,
    .ent_pol, .ent_dmode, .ent_vector, .ent_deliv, .ent_dest, .remote_irr,
    .rirr_clr, .svc_req, .mask_chg_vld, .mask_chg_pin, .mask_chg_val);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected rd_valid", 1, 0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic sel(input logic [31:0] s);
    wr(8'h00, s);
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [NP-1:0] mask_snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 masks", 64'(ent_mask), 64'({NP{1'b1}}));
    chk("R11 remote_irr", 64'(remote_irr), 0);
    chk("R11 vectors", 64'(ent_vector[63:0]), 0);
    rd(8'h00, 32'h0, "R11 select");
    rd(8'h10, 32'h0, "R11 id");
    // R1 select readback and other offsets
    sel(32'hCAFE_0001);
    rd(8'h00, 32'hCAFE_0001, "R1 select readback");
    rd(8'h20, 32'h0, "R1 other offset");
    wr(8'h04, 32'h1234_5678);
    rd(8'h00, 32'hCAFE_0001, "R1 write to other offset");
    rd(8'h10, 32'h0, "R6 huge select read");
    // R3 version
    sel(32'h1);
    rd(8'h10, {8'h0, 8'(NP - 1), 8'h0, 8'h11}, "R3 version");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, {8'h0, 8'(NP - 1), 8'h0, 8'h11}, "R3 version write ignored");
    // R4 id and arbitration
    sel(32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0F00_0000, "R4 id");
    sel(32'h2);
    rd(8'h10, 32'h0F00_0000, "R4 arb mirror");
    wr(8'h10, 32'h0);
    sel(32'h0);
    rd(8'h10, 32'h0F00_0000, "R4 arb write ignored");
    // R5 entry 3 low half, mask unchanged
    sel(32'h16);
    wr(8'h10, 32'h0001_FB55);
    chk("R9 no event when mask unchanged", 64'(mask_chg_vld), 0);
    rd(8'h10, 32'h0001_AB55, "R5 low half readback");
    chk("R5 vector", 64'(ent_vector[24 +: 8]), 64'h55);
    chk("R5 delivery", 64'(ent_deliv[9 +: 3]), 64'h3);
    chk("R5 trig/pol/dmode", 64'({ent_trig[3], ent_pol[3], ent_dmode[3]}), 64'h7);
    chk("R5 neighbour untouched", 64'(ent_vector[16 +: 8]), 0);
    // R9 mask change
    wr(8'h10, 32'h0000_AB55);
    chk("R9 event", 64'({mask_chg_vld, 5'(mask_chg_pin), mask_chg_val}), 64'({1'b1, 5'd3, 1'b0}));
    @(negedge clk);
    chk("R9 single pulse", 64'(mask_chg_vld), 0);
    chk("R9 mask output", 64'(ent_mask[3]), 0);
    // R5 high half
    sel(32'h17);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hFF00_0000, "R5 high half readback");
    chk("R5 dest", 64'(ent_dest[24 +: 8]), 64'hFF);
    // R6 out of range
    mask_snap = ent_mask;
    sel(32'h10 + 2 * NP);
    wr(8'h10, 32'h0);
    chk("R6 masks untouched", 64'(ent_mask), 64'(mask_snap));
    rd(8'h10, 32'h0, "R6 out of range read");
    // R7 remote IRR
    @(negedge clk); rirr_set[3] = 1;
    @(negedge clk); rirr_set[3] = 0;
    chk("R7 set", 64'(remote_irr[3]), 1);
    sel(32'h16);
    rd(8'h10, 32'h0000_EB55, "R7 bit14 readback");
    sel(32'h17);
    wr(8'h10, 32'hAA00_0000);
    chk("R7 high write keeps", 64'(remote_irr[3]), 1);
    chk("R7 no clear on high", 64'(rirr_clr), 0);
    sel(32'h16);
    wr(8'h10, 32'h0000_AB55);
    chk("R7 clear pulse", 64'(rirr_clr), 64'(NP'(1) << 3));
    chk("R7 cleared", 64'(remote_irr[3]), 0);
    // R8 service request
    pin_request = NP'(1) << 5;
    sel(32'h1B);
    wr(8'h10, 32'h1100_0000);
    chk("R8 service pulse", 64'(svc_req), 64'(NP'(1) << 5));
    @(negedge clk);
    chk("R8 pulse ends", 64'(svc_req), 0);
    pin_request = '0;
    wr(8'h10, 32'h2200_0000);
    chk("R8 no pending no pulse", 64'(svc_req), 0);
    // R10 size filter
    sel(32'h16);
    wr(8'h10, 32'h0001_0077, 4'd2);
    rd(8'h10, 32'h0000_AB55, "R10 size 2 ignored");
    wr(8'h10, 32'h0001_0077, 4'd8);
    rd(8'h10, 32'h0001_0077, "R10 size 8 accepted");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R2 missing read data", 64'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule